// File: doc/BRIEF.md
# Folded Single-Multiplier FIR Filter

This block is a 17-tap (order 16) finite impulse response filter. It takes a stream of signed fixed-point samples in and gives a stream of filtered samples out. Both streams use a valid/ready handshake in the AXI4-Stream style. Samples and coefficients are 18-bit two's-complement words with 15 fractional bits. The seventeen coefficients are fixed at elaboration through the parameters `K0` to `K16`, and negative values are allowed.

The block owns a single multiplier. A sequencer steps that multiplier through the taps, one tap per clock cycle. When a sample is accepted, it shifts into a 17-entry history. The accumulator is cleared, and seventeen multiply-accumulate steps follow. The sum is then shifted right by 15 bits, clamped to the 18-bit range and held on the output until the consumer takes it. The block accepts no new input while a sum is being built or while a result waits. The clock must therefore run at least about 19 times faster than the sample rate. A 100 MHz clock with 500 ksps input is one example that meets this.

Top module: `fold_fir`

## Requirements
- R1: A synchronous active-high reset clears the history, the accumulator and the sequencer. After reset `s_tready` is 1 and `m_tvalid` is 0, and the next output is computed as if all earlier samples were zero.
- R2: `s_tready` is 1 only when no sum is being built and no result is pending. It is 0 in the cycle after a sample is accepted.
- R3: A sample whose `s_tvalid` is high for exactly one cycle while `s_tready` is 1 is captured.
- R4: With x[0] as the newest accepted sample and x[k] as the sample accepted k samples earlier, each output equals floor(sum over k = 0..16 of Kk * x[k] / 2^15). Kk and x[k] are signed Q15, so an input of 32768 (1.0) after zero history returns K0 itself.
- R5: `m_tvalid` rises exactly 17 clock edges after the edge that accepts the sample.
- R6: When the scaled sum is outside the 18-bit signed range, the output is clamped to 131071 above the range or to -131072 below it.
- R7: While `m_tvalid` is 1 and `m_tready` is 0, `m_tvalid` and `m_tdata` stay unchanged. In the cycle after a handshake, `m_tvalid` is 0 and `s_tready` is 1.
- R8: An `s_tvalid` pulse while `s_tready` is 0 is ignored, and the sample never enters the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tvalid | input | 1 | Input sample valid |
| s_tready | output | 1 | Filter idle, can take a sample |
| s_tdata | input | 18 | Input sample, signed Q15 |
| m_tvalid | output | 1 | Filtered sample valid |
| m_tready | input | 1 | Consumer takes the filtered sample |
| m_tdata | output | 18 | Filtered sample, signed Q15 |

## Verification
The acceptance edge is the reference point for each sample. `s_tready` must be low one cycle later, and the result must appear on the seventeenth edge after it. The bench drives inputs on falling edges and counts falling edges from the acceptance edge to the first `m_tvalid`. It compares that count with 17 and then compares the data with a Q15 model of the history and coefficients. After a handshake, the bench checks on the next falling edge that `m_tvalid` has cleared and `s_tready` has returned. While the consumer stalls, the bench checks every falling edge for held data. Pulses sent while the filter is busy are judged by the value of the following output.

// File: rtl/fir_pkg.sv
package fir_pkg;
    localparam int DATA_W = 18;
    localparam int COEF_W = 18;
    localparam int FRAC_W = 15;
    localparam int NTAPS  = 17;
    localparam int IDX_W  = $clog2(NTAPS);
    localparam int ACC_W  = DATA_W + COEF_W + $clog2(NTAPS);

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic [IDX_W-1:0]         idx_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

    localparam acc_t ACC_HI = acc_t'(2**(DATA_W-1) - 1);
    localparam acc_t ACC_LO = acc_t'(-(2**(DATA_W-1)));

    // drop fraction bits of the product sum, clamp to the sample range
    function automatic sample_t scale_sat(input acc_t a);
        acc_t s;
        s = a >>> FRAC_W;
        if (s > ACC_HI)      return sample_t'(ACC_HI);
        else if (s < ACC_LO) return sample_t'(ACC_LO);
        else                 return sample_t'(s);
    endfunction
endpackage

// File: rtl/fir_hist.sv
module fir_hist
    import fir_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  sample_t din,
    input  idx_t    rd_idx,
    output sample_t rd_data
);
    sample_t line [NTAPS];

    always_ff @(posedge clk) begin
        if (rst)       line[0] <= '0;
        else if (load) line[0] <= din;
    end

    for (genvar g = 1; g < NTAPS; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)       line[g] <= '0;
            else if (load) line[g] <= line[g-1];
        end
    end

    assign rd_data = line[rd_idx];

    // R8
    hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(line[0]) && $stable(line[NTAPS-1])));
endmodule

// File: rtl/fir_seq.sv
module fir_seq
    import fir_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_fire,
    input  logic   out_fire,
    output phase_e phase,
    output idx_t   tap_idx,
    output logic   step,
    output logic   last
);
    localparam idx_t LAST_IDX = idx_t'(NTAPS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            tap_idx <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (in_fire) begin
                    phase   <= PH_RUN;
                    tap_idx <= '0;
                end
                PH_RUN: begin
                    if (tap_idx == LAST_IDX) phase <= PH_HOLD;
                    else                     tap_idx <= tap_idx + idx_t'(1);
                end
                PH_HOLD: if (out_fire) phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign step = (phase == PH_RUN);
    assign last = step && (tap_idx == LAST_IDX);

    // R5
    seq_order_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !last) |=> (step && tap_idx == $past(tap_idx) + idx_t'(1)));
endmodule

// File: rtl/fir_mac.sv
module fir_mac
    import fir_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clear,
    input  logic    step,
    input  sample_t x,
    input  coef_t   c,
    output sample_t result
);
    acc_t acc;
    acc_t prod;
    acc_t acc_next;

    assign prod     = acc_t'(x) * acc_t'(c);
    assign acc_next = acc + prod;
    assign result   = scale_sat(acc_next);

    always_ff @(posedge clk) begin
        if (rst || clear) acc <= '0;
        else if (step)    acc <= acc_next;
    end

    // R1
    acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (acc == '0));
endmodule

// File: rtl/fold_fir.sv
module fold_fir
    import fir_pkg::*;
#(
    parameter coef_t K0  = -18'sd310,
    parameter coef_t K1  = -18'sd420,
    parameter coef_t K2  = 18'sd0,
    parameter coef_t K3  = 18'sd980,
    parameter coef_t K4  = 18'sd2150,
    parameter coef_t K5  = 18'sd3300,
    parameter coef_t K6  = 18'sd4250,
    parameter coef_t K7  = 18'sd4820,
    parameter coef_t K8  = 18'sd5000,
    parameter coef_t K9  = 18'sd4820,
    parameter coef_t K10 = 18'sd4250,
    parameter coef_t K11 = 18'sd3300,
    parameter coef_t K12 = 18'sd2150,
    parameter coef_t K13 = 18'sd980,
    parameter coef_t K14 = 18'sd0,
    parameter coef_t K15 = -18'sd420,
    parameter coef_t K16 = -18'sd310
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic [DATA_W-1:0] s_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [DATA_W-1:0] m_tdata
);
    localparam coef_t COEFS [NTAPS] = '{K0, K1, K2, K3, K4, K5, K6, K7, K8,
                                        K9, K10, K11, K12, K13, K14, K15, K16};

    phase_e  phase;
    idx_t    tap_idx;
    logic    step, last;
    logic    in_fire, out_fire;
    sample_t hist_x;
    coef_t   coef_sel;
    sample_t mac_res;
    sample_t out_q;

    assign s_tready = (phase == PH_IDLE);
    assign in_fire  = s_tvalid && s_tready;
    assign out_fire = m_tvalid && m_tready;
    assign coef_sel = COEFS[tap_idx];

    fir_seq seq_i (
        .clk(clk), .rst(rst), .in_fire(in_fire), .out_fire(out_fire),
        .phase(phase), .tap_idx(tap_idx), .step(step), .last(last)
    );

    fir_hist hist_i (
        .clk(clk), .rst(rst), .load(in_fire), .din(sample_t'(s_tdata)),
        .rd_idx(tap_idx), .rd_data(hist_x)
    );

    fir_mac mac_i (
        .clk(clk), .rst(rst), .clear(in_fire), .step(step),
        .x(hist_x), .c(coef_sel), .result(mac_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            m_tvalid <= 1'b0;
            out_q    <= '0;
        end else if (last) begin
            m_tvalid <= 1'b1;
            out_q    <= mac_res;
        end else if (out_fire) begin
            m_tvalid <= 1'b0;
        end
    end

    assign m_tdata = out_q;

    // R2
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        !(s_tready && m_tvalid));
    // R2
    accept_drop_chk: assert property (@(posedge clk) disable iff (rst)
        in_fire |=> !s_tready);
    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)));
    // R7
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && m_tready) |=> (!m_tvalid && s_tready));
endmodule

// File: tb/fold_fir_tb_top.sv
module fold_fir_tb_top;
    localparam time CLK_P = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [17:0] s_tdata = '0;
    logic        m_tvalid;
    logic        m_tready = 1'b1;
    logic [17:0] m_tdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    longint kv [17] = '{16384, -8192, 12000, 4000, -3000, 2000, 1500, -1000,
                        8000, 700, 600, -500, 400, 300, -200, 100, 20000};
    longint hist [17];

    always #(CLK_P/2) clk = ~clk;

    fold_fir #(
        .K0(18'sd16384), .K1(-18'sd8192), .K2(18'sd12000), .K3(18'sd4000),
        .K4(-18'sd3000), .K5(18'sd2000), .K6(18'sd1500), .K7(-18'sd1000),
        .K8(18'sd8000), .K9(18'sd700), .K10(18'sd600), .K11(-18'sd500),
        .K12(18'sd400), .K13(18'sd300), .K14(-18'sd200), .K15(18'sd100),
        .K16(18'sd20000)
    ) dut_i (
        .clk(clk), .rst(rst), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .s_tdata(s_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tdata(m_tdata)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint model();
        longint acc = 0;
        longint s;
        for (int k = 0; k < 17; k++) acc += kv[k] * hist[k];
        s = acc >>> 15;
        if (s > 131071)  s = 131071;
        if (s < -131072) s = -131072;
        return s;
    endfunction

    function automatic longint dout();
        return longint'($signed(m_tdata));
    endfunction

    task automatic clear_model();
        for (int k = 0; k < 17; k++) hist[k] = 0;
    endtask

    // drive one single-cycle valid pulse, returns at the falling edge after acceptance
    task automatic push_start(input longint v);
        chk("R2 ready before push", longint'(s_tready), 1);
        s_tvalid = 1'b1;
        s_tdata  = v[17:0];
        @(negedge clk);
        s_tvalid = 1'b0;
        chk("R2 ready drops after accept", longint'(s_tready), 0);
        for (int k = 16; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = v;
    endtask

    task automatic wait_out(input string req, input bit poke);
        int lat = 0;
        longint exp = model();
        while (m_tvalid !== 1'b1 && lat < 40) begin
            if (poke && lat == 3) begin
                s_tvalid = 1'b1;
                s_tdata  = 18'h15555;
            end else begin
                s_tvalid = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        s_tvalid = 1'b0;
        chk("R5 latency", lat, 17);
        chk(req, dout(), exp);
        if (m_tready) begin
            @(negedge clk);
            chk("R7 valid clears after handshake", longint'(m_tvalid), 0);
            chk("R7 ready returns after handshake", longint'(s_tready), 1);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        clear_model();
        chk("R1 reset ready", longint'(s_tready), 1);
        chk("R1 reset valid", longint'(m_tvalid), 0);
    endtask

    task automatic t_impulse();
        for (int n = 0; n < 17; n++) begin
            push_start(n == 0 ? 32768 : 0);
            wait_out("R3 R4 impulse tap", 0);
            checks++;
            if (dout() !== kv[n]) begin
                errors++;
                $display("FAIL R4 tap %0d actual=%0d expected=%0d", n, dout(), kv[n]);
            end
        end
    endtask

    task automatic t_mixed();
        for (int n = 0; n < 30; n++) begin
            longint v = longint'(((n * 37921 + 12345) % 262144) - 131072) / 3;
            push_start(v);
            wait_out("R4 mixed pattern", 0);
        end
    endtask

    task automatic t_saturate();
        for (int n = 0; n < 17; n++) begin
            push_start(131071);
            wait_out("R6 positive run", 0);
        end
        chk("R6 clamp high", dout(), 131071);
        for (int n = 0; n < 17; n++) begin
            push_start(-131072);
            wait_out("R6 negative run", 0);
        end
        chk("R6 clamp low", dout(), -131072);
    endtask

    task automatic t_stall();
        longint held;
        push_start(20000);
        wait_out("R8 pulse during run ignored", 1);
        m_tready = 1'b0;
        push_start(-7000);
        wait_out("R4 stalled result", 0);
        held = dout();
        for (int i = 0; i < 5; i++) begin
            s_tvalid = (i == 1);
            s_tdata  = 18'h0AAAA;
            @(negedge clk);
            s_tvalid = 1'b0;
            chk("R7 valid held", longint'(m_tvalid), 1);
            chk("R7 data held", dout(), held);
            chk("R8 ready low while pending", longint'(s_tready), 0);
        end
        m_tready = 1'b1;
        @(negedge clk);
        chk("R7 valid clears after stall", longint'(m_tvalid), 0);
        chk("R7 ready after stall", longint'(s_tready), 1);
        push_start(3333);
        wait_out("R8 pulses while busy left history unchanged", 0);
    endtask

    task automatic t_mid_reset();
        push_start(90000);
        repeat (5) @(negedge clk);
        t_reset();
        repeat (20) @(negedge clk);
        chk("R1 no output after mid-run reset", longint'(m_tvalid), 0);
        push_start(32768);
        wait_out("R1 history cleared by reset", 0);
        chk("R1 first output equals K0", dout(), kv[0]);
    endtask

    initial begin
        clear_model();
        @(negedge clk);
        t_reset();
        t_impulse();
        t_mixed();
        t_saturate();
        t_stall();
        t_mid_reset();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule